// File: doc/BRIEF.md
# Peripheral Output-Transfer Handshake Unit

This block is the device end of an output transfer. A host announces the transfer with an instruction-sync level plus a unit number and a wait request. The unit answers with a sync return, and also with a test return when its output buffer can take a new word. If the buffer is busy, the answer depends on the wait request. With wait set, the unit gives no answer and keeps testing the buffer while the host stalls. With wait clear, it answers with sync alone, so the host skips the transfer.

After the sync level drops, the host raises data-here with the word on the I/O bus. One strobe loads the word into the 16-bit output register, raises data-accepted and marks the buffer busy. Data-accepted holds until the host drops data-here. A downstream consumer frees the buffer again with a one-cycle read pulse.

The controller is a state machine with five states:
- IDLE: no exchange in progress.
- STALL: waiting for the buffer while the host is held.
- SYNC: sync returned alone.
- SYNC_TEST: sync and test returned.
- ACCEPT: data-accepted held.

Transitions:
- IDLE to SYNC_TEST on a selected sync with the buffer free.
- IDLE to STALL on a selected sync with the buffer busy and wait set.
- IDLE to SYNC on a selected sync with the buffer busy and wait clear.
- STALL to SYNC_TEST when the buffer frees.
- STALL, SYNC or SYNC_TEST to IDLE when sync drops.
- IDLE to ACCEPT on a selected data-here with the buffer free; this is the load strobe.
- ACCEPT to IDLE when data-here drops.

Top module: `out_handshake_unit`

## Requirements
- R1: After reset, sync_ret, test_ret and data_acc are 0, out_word is 0 and buf_ready is 1.
- R2: When ins_sync is high, unit_num equals UNIT_ID and buf_ready is 1 in the idle state, sync_ret and test_ret both go high at the next clock edge.
- R3: When the buffer is busy and wait_req is 1 on a selected sync, no return is given while the buffer stays busy. Both returns rise one edge after buf_ready becomes 1, provided sync is still held.
- R4: When the buffer is busy and wait_req is 0 on a selected sync, sync_ret goes high at the next edge while test_ret stays 0.
- R5: When ins_sync is low at a clock edge, sync_ret and test_ret are both 0 after that edge.
- R6: A data_here with a selected unit, buf_ready at 1 and ins_sync low loads io_word into out_word, sets data_acc and clears buf_ready, all at the same edge.
- R7: data_acc stays 1 while data_here stays high, and clears at the first edge where data_here is low.
- R8: A data_here that arrives while buf_ready is 0 leaves data_acc at 0 and out_word unchanged.
- R9: A one-cycle word_taken pulse sets buf_ready at the next edge. If a load happens at the same edge, the load wins and buf_ready is 0.
- R10: A sync or data_here with unit_num different from UNIT_ID produces no return, no data_acc and no change to out_word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_sync | input | 1 | Host instruction-sync level |
| unit_num | input | UNIT_W | Unit number carried with the instruction |
| wait_req | input | 1 | Host requests a stall while the buffer is busy |
| data_here | input | 1 | Host signals the data word is on the bus |
| io_word | input | DATA_W | I/O bus word |
| word_taken | input | 1 | Consumer read pulse; frees the buffer |
| sync_ret | output | 1 | Sync return to host |
| test_ret | output | 1 | Test return (buffer ready) to host |
| data_acc | output | 1 | Data accepted |
| out_word | output | DATA_W | Output register |
| buf_ready | output | 1 | Buffer can take a new word |

## Verification
The assertions take for granted that the host never raises data_here while ins_sync is still high. They also assume the host holds unit_num, wait_req and the bus word steady during an exchange. The stimulus follows this host discipline throughout: sync is dropped and the returns are seen to clear before any data-here is driven. The sweep covers every unit number with both wait settings and both buffer states. The stall case, the loses-to-load read pulse and the ignored data strobes are driven as separate, ordered episodes.

// File: rtl/ohs_pkg.sv
package ohs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_STALL,
        ST_SYNC,
        ST_SYNC_TEST,
        ST_ACCEPT
    } hs_state_t;
endpackage

// File: rtl/ohs_fsm.sv
module ohs_fsm
    import ohs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic isync,
    input  logic sel,
    input  logic wait_flag,
    input  logic cdh,
    input  logic rdy,
    output logic usr,
    output logic utr,
    output logic uda,
    output logic load
);
    hs_state_t state, nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt  = state;
        load = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (isync && sel) begin
                    if (rdy)            nxt = ST_SYNC_TEST;
                    else if (wait_flag) nxt = ST_STALL;
                    else                nxt = ST_SYNC;
                end else if (!isync && cdh && sel && rdy) begin
                    nxt  = ST_ACCEPT;
                    load = 1'b1;
                end
            end
            ST_STALL: begin
                if (!isync)   nxt = ST_IDLE;
                else if (rdy) nxt = ST_SYNC_TEST;
            end
            ST_SYNC, ST_SYNC_TEST: begin
                if (!isync) nxt = ST_IDLE;
            end
            ST_ACCEPT: begin
                if (!cdh) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        usr = 1'b0;
        utr = 1'b0;
        uda = 1'b0;
        unique case (state)
            ST_SYNC:      usr = 1'b1;
            ST_SYNC_TEST: begin usr = 1'b1; utr = 1'b1; end
            ST_ACCEPT:    uda = 1'b1;
            default:      ;
        endcase
    end

    // R2
    ready_both_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && isync && sel && rdy) |=> (usr && utr));
    // R3
    stall_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && isync && sel && !rdy && wait_flag) |=> (!usr && !utr));
    // R4
    sync_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && isync && sel && !rdy && !wait_flag) |=> (usr && !utr));
    // R5
    sync_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !isync |=> (!usr && !utr));
    // R7
    uda_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (uda && !cdh) |=> !uda);
    // R7
    uda_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (uda && cdh) |=> uda);
endmodule

// File: rtl/ohs_outreg.sv
module ohs_outreg #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              rd,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              rdy
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout <= '0;
            rdy  <= 1'b1;
        end else begin
            if (load)    dout <= din;
            if (load)    rdy  <= 1'b0;
            else if (rd) rdy  <= 1'b1;
        end
    end

    // R6
    load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (!rdy && dout == $past(din)));
    // R9
    read_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !load) |=> rdy);
    // R8
    hold_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(dout));
endmodule

// File: rtl/out_handshake_unit.sv
module out_handshake_unit #(
    parameter int DATA_W  = 16,
    parameter int UNIT_W  = 4,
    parameter int UNIT_ID = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ins_sync,
    input  logic [UNIT_W-1:0] unit_num,
    input  logic              wait_req,
    input  logic              data_here,
    input  logic [DATA_W-1:0] io_word,
    input  logic              word_taken,
    output logic              sync_ret,
    output logic              test_ret,
    output logic              data_acc,
    output logic [DATA_W-1:0] out_word,
    output logic              buf_ready
);
    localparam logic [UNIT_W-1:0] MY_UNIT = UNIT_W'(UNIT_ID);

    logic sel;
    logic load;

    assign sel = (unit_num == MY_UNIT);

    ohs_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .isync     (ins_sync),
        .sel       (sel),
        .wait_flag (wait_req),
        .cdh       (data_here),
        .rdy       (buf_ready),
        .usr       (sync_ret),
        .utr       (test_ret),
        .uda       (data_acc),
        .load      (load)
    );

    ohs_outreg #(.DATA_W(DATA_W)) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .rd    (word_taken),
        .din   (io_word),
        .dout  (out_word),
        .rdy   (buf_ready)
    );

    // R8
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_here && !buf_ready && !data_acc && !ins_sync) |=> (!data_acc && $stable(out_word)));
    // R10
    foreign_unit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_ret && !data_acc && !sel) |=> (!sync_ret && !test_ret && !data_acc));
endmodule

// File: tb/out_handshake_unit_test.sv
module out_handshake_unit_test;
    localparam int DW = 16;
    localparam int UW = 4;
    localparam int ID = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ins_sync = 1'b0;
    logic [UW-1:0] unit_num = '0;
    logic wait_req = 1'b0;
    logic data_here = 1'b0;
    logic [DW-1:0] io_word = '0;
    logic word_taken = 1'b0;
    logic sync_ret, test_ret, data_acc, buf_ready;
    logic [DW-1:0] out_word;

    int n_chk = 0;
    int n_bad = 0;
    logic exp_rdy;
    logic [DW-1:0] exp_word;
    logic done = 1'b0;

    always #5 clk = ~clk;

    out_handshake_unit #(.DATA_W(DW), .UNIT_W(UW), .UNIT_ID(ID)) uut (
        .clk(clk), .rst_n(rst_n), .ins_sync(ins_sync), .unit_num(unit_num),
        .wait_req(wait_req), .data_here(data_here), .io_word(io_word),
        .word_taken(word_taken), .sync_ret(sync_ret), .test_ret(test_ret),
        .data_acc(data_acc), .out_word(out_word), .buf_ready(buf_ready)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_load(input logic [DW-1:0] w);
        unit_num = UW'(ID); io_word = w; data_here = 1'b1;
        step();
        exp_word = w; exp_rdy = 1'b0;
        chk(data_acc === 1'b1, "R6 data_acc", 32'(data_acc), 1);
        chk(out_word === exp_word, "R6 out_word", 32'(out_word), 32'(exp_word));
        chk(buf_ready === 1'b0, "R6 buf_ready", 32'(buf_ready), 0);
        step();
        chk(data_acc === 1'b1, "R7 hold", 32'(data_acc), 1);
        data_here = 1'b0;
        step();
        chk(data_acc === 1'b0, "R7 release", 32'(data_acc), 0);
    endtask

    task automatic free_buf();
        word_taken = 1'b1;
        step();
        word_taken = 1'b0;
        exp_rdy = 1'b1;
        chk(buf_ready === 1'b1, "R9 read frees", 32'(buf_ready), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        exp_rdy = 1'b1; exp_word = '0;
        // R1
        chk(sync_ret === 1'b0 && test_ret === 1'b0 && data_acc === 1'b0, "R1 returns",
            {29'd0, sync_ret, test_ret, data_acc}, 0);
        chk(out_word === '0, "R1 out_word", 32'(out_word), 0);
        chk(buf_ready === 1'b1, "R1 buf_ready", 32'(buf_ready), 1);

        for (int u = 0; u < (1 << UW); u++) begin
            for (int w = 0; w < 2; w++) begin
                for (int r = 0; r < 2; r++) begin
                    logic sel_e, usr_e, utr_e;
                    if (r == 0 && exp_rdy) do_load(DW'(16'h1000 + u * 4 + w * 2));
                    if (r == 1 && !exp_rdy) free_buf();
                    sel_e = (u == ID);
                    usr_e = sel_e && (r == 1 || w == 0);
                    utr_e = sel_e && (r == 1);
                    unit_num = UW'(u); wait_req = w[0]; ins_sync = 1'b1;
                    step();
                    // R2 R3 R4 R10
                    chk(sync_ret === usr_e, sel_e ? "R2/R3/R4 sync_ret" : "R10 sync_ret",
                        32'(sync_ret), 32'(usr_e));
                    chk(test_ret === utr_e, sel_e ? "R2/R3/R4 test_ret" : "R10 test_ret",
                        32'(test_ret), 32'(utr_e));
                    if (sel_e && r == 0 && w == 1) begin
                        step();
                        chk(sync_ret === 1'b0, "R3 still stalled", 32'(sync_ret), 0);
                        word_taken = 1'b1;
                        step();
                        word_taken = 1'b0;
                        exp_rdy = 1'b1;
                        chk(sync_ret === 1'b0, "R3 one edge later", 32'(sync_ret), 0);
                        step();
                        chk(sync_ret === 1'b1 && test_ret === 1'b1, "R3 both after ready",
                            {30'd0, sync_ret, test_ret}, 3);
                    end
                    ins_sync = 1'b0;
                    step();
                    chk(sync_ret === 1'b0 && test_ret === 1'b0, "R5 drop",
                        {30'd0, sync_ret, test_ret}, 0);
                end
            end
        end

        // R8: data_here while busy is ignored
        if (exp_rdy) do_load(16'hBEEF);
        unit_num = UW'(ID); io_word = 16'h1234; data_here = 1'b1;
        step();
        chk(data_acc === 1'b0, "R8 no accept", 32'(data_acc), 0);
        chk(out_word === exp_word, "R8 word kept", 32'(out_word), 32'(exp_word));
        data_here = 1'b0;
        step();
        free_buf();

        // R10: foreign unit data_here ignored
        unit_num = UW'(ID + 1); io_word = 16'h5555; data_here = 1'b1;
        step();
        chk(data_acc === 1'b0, "R10 no accept", 32'(data_acc), 0);
        chk(out_word === exp_word, "R10 word kept", 32'(out_word), 32'(exp_word));
        data_here = 1'b0;
        step();

        // R9: read and load at one edge, load wins
        unit_num = UW'(ID); io_word = 16'hA5C3; data_here = 1'b1; word_taken = 1'b1;
        step();
        word_taken = 1'b0;
        chk(buf_ready === 1'b0, "R9 load wins", 32'(buf_ready), 0);
        chk(out_word === 16'hA5C3, "R9 word", 32'(out_word), 32'hA5C3);
        data_here = 1'b0;
        step();
        chk(data_acc === 1'b0, "R7 release", 32'(data_acc), 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule